// File: doc/BRIEF.md
# Multi-Mode Compare Timer with Toggle Output

This block is a synchronous timer that advances its count on a clock-enable tick. It drives an output pin from its compare event with no processor help. A two-bit mode field selects how the count moves. In stop mode the count holds. In up mode it climbs to a period value and then restarts at zero. In continuous mode it runs over its whole range. In up/down mode it rises to the period value and then falls back to zero. The single compare channel watches the period value. When toggle output is enabled, the pin inverts on every compare event, so the block produces a square wave on its own.

Two sticky flags report events. The compare flag marks the move from period−1 to period. The overflow flag marks the move back to zero, and the transition that sets it depends on the mode. Software clears each flag with a one-cycle clear pulse. Registers are loaded through a plain parallel write port with one select bit.

Top module: `cmp_toggle_timer`

## Requirements
- R1: While rst_n is low at a clock edge, the count, the count direction, both flags and out_pin become 0, the mode becomes stop, toggle is disabled and the period becomes 0.
- R2: In stop mode (mode 00), or on any edge where tick is low, the count keeps its value.
- R3: In up mode (mode 01), each tick adds one to the count until it equals the period. The next tick returns it to 0 and sets the overflow flag.
- R4: In continuous mode (mode 10), each tick adds one. The tick at the all-ones value wraps the count to 0 and sets the overflow flag.
- R5: In up/down mode (mode 11), the count rises to the period and then falls to 0 one step per tick. It turns upward again at 0, and the overflow flag is set on the tick that moves it from 1 to 0.
- R6: In every running mode with a nonzero period, the compare flag is set on the tick that moves the count from period−1 to the period.
- R7: With toggle enabled (control bit 2 = 1), out_pin inverts on each compare event, giving a full output period of 2×(period+1) ticks in up mode and 4×period ticks in up/down mode. With toggle disabled, out_pin holds.
- R8: A high cmp_clr or ovf_clr clears the matching flag at the next edge. If the flag's set event occurs in the same cycle, the flag is set instead.
- R9: Writing a new mode keeps the current count. Entering up/down mode from another mode makes the next tick count upward.
- R10: A write with wr_sel = 0 loads the mode from wr_data[1:0] and the toggle enable from wr_data[2]. A write with wr_sel = 1 loads the period from wr_data. Both take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = period register |
| wr_data | input | CNT_W | Write data |
| cmp_clr | input | 1 | Clear pulse for the compare flag |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| count | output | CNT_W | Current count |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| out_pin | output | 1 | Compare output level |

## Verification
The bench builds the timer with CNT_W = 8. This makes the continuous-mode wrap from all-ones to zero reachable in 256 ticks, so that overflow point is checked directly rather than inferred. Small periods of 4, 5 and 10 keep whole up and up/down cycles short. With such short cycles, the toggle spacing of period+1 and 2×period ticks can be measured edge to edge. The same short cycles make the set-versus-clear collision easy to land on an exact tick.

// File: rtl/tmr_pkg.sv
// Shared types and register-map constants for the compare timer.
// Assumes a single-bit register select on the write port.
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } tmr_mode_e;

    localparam logic SEL_CTRL   = 1'b0;
    localparam logic SEL_PERIOD = 1'b1;
    localparam int   CTRL_TOG_BIT = 2;
    localparam int   NUM_FLAGS    = 2;
    localparam int   FLAG_CMP     = 0;
    localparam int   FLAG_OVF     = 1;
endpackage

// File: rtl/tmr_regs.sv
// Control and period registers, loaded through the parallel write port.
// Also flags a write that enters up/down mode from any other mode.
// Assumes CNT_W > CTRL_TOG_BIT + 1.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output tmr_mode_e        mode,
    output logic             tog_en,
    output logic [CNT_W-1:0] period,
    output logic             enter_updn
);
    logic      ctrl_wr;
    tmr_mode_e mode_wdata;
    logic      unused_ctrl_bits;

    assign ctrl_wr          = wr_en && (wr_sel == SEL_CTRL);
    assign mode_wdata       = tmr_mode_e'(wr_data[1:0]);
    assign unused_ctrl_bits = ^wr_data[CNT_W-1:CTRL_TOG_BIT+1];

    // Detect a control write that switches into up/down mode.
    always_comb begin
        enter_updn = ctrl_wr && (mode_wdata == MODE_UPDN) && (mode != MODE_UPDN);
    end

    // Load the control fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_STOP;
            tog_en <= 1'b0;
        end else if (ctrl_wr) begin
            mode   <= mode_wdata;
            tog_en <= wr_data[CTRL_TOG_BIT];
        end
    end

    // Load the period on a period write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
        end else if (wr_en && (wr_sel == SEL_PERIOD)) begin
            period <= wr_data;
        end
    end

    // R10: a control write is visible at the next edge
    a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (mode == tmr_mode_e'($past(wr_data[1:0]))));
    // R10: a period write is visible at the next edge
    a_r10_period_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PERIOD) |=> (period == $past(wr_data)));
endmodule

// File: rtl/tmr_counter.sv
// Count engine for stop, up, continuous and up/down modes.
// Produces one-cycle compare and overflow event strobes on the ticks
// that cause them. Direction bit: 0 = upward, 1 = downward.
// Assumes the period is nonzero when compare events are wanted.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] period,
    input  logic             enter_updn,
    output logic [CNT_W-1:0] count,
    output logic             cmp_evt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic             dir_down;
    logic             dir_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             step;

    assign step = tick && (mode != MODE_STOP);

    // Next count, next direction and overflow event for the active mode.
    always_comb begin
        cnt_nx  = count;
        dir_nx  = dir_down;
        ovf_evt = 1'b0;
        if (step) begin
            unique case (mode)
                MODE_UP: begin
                    if (count >= period) begin
                        cnt_nx  = ZERO;
                        ovf_evt = 1'b1;
                    end else begin
                        cnt_nx = count + ONE;
                    end
                end
                MODE_CONT: begin
                    cnt_nx  = count + ONE;
                    ovf_evt = (count == MAXV);
                end
                MODE_UPDN: begin
                    if (!dir_down) begin
                        if (count >= period) begin
                            dir_nx = 1'b1;
                            cnt_nx = (count == ZERO) ? ZERO : count - ONE;
                        end else begin
                            cnt_nx = count + ONE;
                        end
                    end else begin
                        if (count == ZERO) begin
                            dir_nx = 1'b0;
                            cnt_nx = (period == ZERO) ? ZERO : ONE;
                        end else begin
                            cnt_nx  = count - ONE;
                            ovf_evt = (count == ONE);
                        end
                    end
                end
                default: cnt_nx = count;
            endcase
        end
    end

    // Compare event: the count steps from period-1 up to the period.
    always_comb begin
        cmp_evt = step && (period != ZERO) && (count == period - ONE)
                  && !((mode == MODE_UPDN) && dir_down);
    end

    // Register the count and the direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_down <= 1'b0;
        end else begin
            count    <= cnt_nx;
            dir_down <= enter_updn ? 1'b0 : dir_nx;
        end
    end

    // R1: reset clears the count
    a_r1_count_reset: assert property (@(posedge clk)
        !rst_n |=> (count == ZERO));
    // R2: no step means no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));
    // R3: up mode below the period advances by one
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_UP && count < period) |=> (count == $past(count) + ONE));
    // R4: continuous overflow lands on zero
    a_r4_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && mode == MODE_CONT) |=> (count == ZERO));
    // R5: up/down overflow comes only from a count of one
    a_r5_updn_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && mode == MODE_UPDN) |-> (count == ONE));
    // R6: after a compare event the count equals the period
    a_r6_cmp_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> (count == $past(period)));
endmodule

// File: rtl/tmr_flag.sv
// One sticky interrupt flag: set by an event strobe, cleared by a
// write-one-to-clear pulse; a set in the same cycle wins over the clear.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Update the flag with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R8: a set event always leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R8: a clear with no set drops the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/tmr_outunit.sv
// Compare output stage: inverts the pin level on each compare event
// while toggle output is enabled, otherwise holds the level.
module tmr_outunit (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_en,
    input  logic cmp_evt,
    output logic out_pin
);
    // Toggle the output level on enabled compare events.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_pin <= 1'b0;
        else if (tog_en && cmp_evt)  out_pin <= ~out_pin;
    end

    // R7: enabled compare inverts the pin
    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_en && cmp_evt) |=> (out_pin != $past(out_pin)));
    // R7: otherwise the pin holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tog_en && cmp_evt) |=> $stable(out_pin));
endmodule

// File: rtl/cmp_toggle_timer.sv
// Top of the multi-mode compare timer. Wires the register block, the
// count engine, the two sticky flags and the toggle output stage.
// Assumes tick is synchronous to clk; all state uses synchronous reset.
module cmp_toggle_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cmp_clr,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             out_pin
);
    tmr_mode_e        mode;
    logic             tog_en;
    logic [CNT_W-1:0] period;
    logic             enter_updn;
    logic             cmp_evt;
    logic             ovf_evt;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .mode(mode), .tog_en(tog_en),
        .period(period), .enter_updn(enter_updn)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .period(period), .enter_updn(enter_updn), .count(count),
        .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
    );

    assign flag_set[FLAG_CMP] = cmp_evt;
    assign flag_set[FLAG_OVF] = ovf_evt;
    assign flag_clr[FLAG_CMP] = cmp_clr;
    assign flag_clr[FLAG_OVF] = ovf_clr;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        tmr_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(flag_set[g]),
            .clr(flag_clr[g]), .flag(flag_q[g])
        );
    end

    assign cmp_flag = flag_q[FLAG_CMP];
    assign ovf_flag = flag_q[FLAG_OVF];

    tmr_outunit u_out (
        .clk(clk), .rst_n(rst_n), .tog_en(tog_en),
        .cmp_evt(cmp_evt), .out_pin(out_pin)
    );

    // R1: reset leaves flags and output low
    a_r1_outputs_reset: assert property (@(posedge clk)
        !rst_n |=> (!cmp_flag && !ovf_flag && !out_pin));
    // R9: a mode write alone does not move the count
    a_r9_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && !tick) |=> $stable(count));
endmodule

// File: tb/cmp_toggle_timer_bench.sv
module cmp_toggle_timer_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         cmp_clr = 1'b0;
    logic         ovf_clr = 1'b0;
    logic [W-1:0] count;
    logic         cmp_flag;
    logic         ovf_flag;
    logic         out_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_toggle_timer #(.CNT_W(W)) u_cmp_toggle_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cmp_clr(cmp_clr),
        .ovf_clr(ovf_clr), .count(count), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .out_pin(out_pin)
    );

    // Vector: mode[37:36] tog[35] period[34:27] ticks[26:11]
    //         count[10:3] cmp[2] ovf[1] out[0]
    localparam int NV = 15;
    localparam logic [37:0] TBL [0:NV-1] = '{
        {2'd1, 1'b1, 8'd4,  16'd3,   8'd3,   1'b0, 1'b0, 1'b0}, // R3
        {2'd1, 1'b1, 8'd4,  16'd4,   8'd4,   1'b1, 1'b0, 1'b1}, // R3 R6 R7
        {2'd1, 1'b1, 8'd4,  16'd5,   8'd0,   1'b1, 1'b1, 1'b1}, // R3
        {2'd1, 1'b1, 8'd4,  16'd9,   8'd4,   1'b1, 1'b1, 1'b0}, // R3 R7
        {2'd2, 1'b1, 8'd10, 16'd10,  8'd10,  1'b1, 1'b0, 1'b1}, // R4 R6
        {2'd2, 1'b1, 8'd10, 16'd255, 8'd255, 1'b1, 1'b0, 1'b1}, // R4
        {2'd2, 1'b1, 8'd10, 16'd256, 8'd0,   1'b1, 1'b1, 1'b1}, // R4
        {2'd3, 1'b1, 8'd5,  16'd5,   8'd5,   1'b1, 1'b0, 1'b1}, // R5 R6
        {2'd3, 1'b1, 8'd5,  16'd7,   8'd3,   1'b1, 1'b0, 1'b1}, // R5
        {2'd3, 1'b1, 8'd5,  16'd9,   8'd1,   1'b1, 1'b0, 1'b1}, // R5
        {2'd3, 1'b1, 8'd5,  16'd10,  8'd0,   1'b1, 1'b1, 1'b1}, // R5
        {2'd3, 1'b1, 8'd5,  16'd11,  8'd1,   1'b1, 1'b1, 1'b1}, // R5
        {2'd3, 1'b1, 8'd5,  16'd15,  8'd5,   1'b1, 1'b1, 1'b0}, // R5 R7
        {2'd0, 1'b1, 8'd5,  16'd7,   8'd0,   1'b0, 1'b0, 1'b0}, // R2
        {2'd1, 1'b0, 8'd4,  16'd4,   8'd4,   1'b1, 1'b0, 1'b0}  // R7 toggle off
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; cmp_clr = 1'b0; ovf_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Apply n ticks; returns at a negedge after the last ticked edge.
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Tick one at a time and return the tick numbers of the first two toggles.
    task automatic toggle_gap(input int limit, output int first, output int second);
        logic prev;
        int seen;
        prev = out_pin; seen = 0; first = -1; second = -1;
        for (int k = 1; k <= limit; k++) begin
            run(1);
            if (out_pin != prev) begin
                if (seen == 0) first = k; else if (seen == 1) second = k;
                seen++;
                prev = out_pin;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int a, b;
        // R1: reset state after some activity
        do_reset();
        wr(1'b1, 3); wr(1'b0, 5);
        run(3);
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 cmp_flag", cmp_flag, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 out_pin", out_pin, 0);
        run(4);
        chk("R1 mode is stop after reset", count, 0);

        // Vector table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wr(1'b1, int'(TBL[v][34:27]));
            wr(1'b0, int'({TBL[v][35], TBL[v][37:36]}));
            run(int'(TBL[v][26:11]));
            chk($sformatf("R3/R4/R5 vec%0d count", v), count, int'(TBL[v][10:3]));
            chk($sformatf("R6 vec%0d cmp_flag", v), cmp_flag, int'(TBL[v][2]));
            chk($sformatf("R3/R4/R5 vec%0d ovf_flag", v), ovf_flag, int'(TBL[v][1]));
            chk($sformatf("R7 vec%0d out_pin", v), out_pin, int'(TBL[v][0]));
        end

        // R2: tick low holds the count in a running mode
        do_reset();
        wr(1'b1, 9); wr(1'b0, 1);
        run(3);
        repeat (5) @(negedge clk);
        chk("R2 tick low holds", count, 3);

        // R9: switching to stop keeps the count, then holds under ticks
        wr(1'b0, 0);
        chk("R9 count kept on mode write", count, 3);
        run(4);
        chk("R2 stop holds under ticks", count, 3);
        // R9: switch to continuous resumes from the kept count
        wr(1'b0, 2);
        run(1);
        chk("R9 continuous resumes", count, 4);

        // R9: entering up/down after descending restarts upward
        do_reset();
        wr(1'b1, 5); wr(1'b0, 3);
        run(7);                       // 0..5 then 4,3 : count 3, descending
        chk("R5 descending count", count, 3);
        wr(1'b0, 1);                  // up mode, count kept
        wr(1'b0, 3);                  // back to up/down
        run(1);
        chk("R9 up/down entry counts upward", count, 4);

        // R7: toggle spacing in up mode, period 4 -> every 5 ticks
        do_reset();
        wr(1'b1, 4); wr(1'b0, 5);
        toggle_gap(12, a, b);
        chk("R7 up first toggle tick", a, 4);
        chk("R7 up half period 2x(P+1)/2", b - a, 5);

        // R7: toggle spacing in up/down mode, period 5 -> every 10 ticks
        do_reset();
        wr(1'b1, 5); wr(1'b0, 7);
        toggle_gap(20, a, b);
        chk("R7 updn first toggle tick", a, 5);
        chk("R7 updn half period 4P/2", b - a, 10);

        // R8: clear pulses, and set winning over a simultaneous clear
        do_reset();
        wr(1'b1, 4); wr(1'b0, 1);
        run(3);
        @(negedge clk);
        tick = 1'b1; cmp_clr = 1'b1;  // compare event and clear together
        @(negedge clk);
        tick = 1'b0; cmp_clr = 1'b0;
        chk("R8 set wins over clear (cmp)", cmp_flag, 1);
        @(negedge clk);
        tick = 1'b1; ovf_clr = 1'b1;  // overflow event and clear together
        @(negedge clk);
        tick = 1'b0; ovf_clr = 1'b0;
        chk("R8 set wins over clear (ovf)", ovf_flag, 1);
        @(negedge clk);
        cmp_clr = 1'b1;
        @(negedge clk);
        cmp_clr = 1'b0;
        chk("R8 cmp cleared", cmp_flag, 0);
        chk("R8 ovf untouched by cmp clear", ovf_flag, 1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R8 ovf cleared", ovf_flag, 0);

        // R10: period write takes effect; control bit 2 drives toggle
        do_reset();
        wr(1'b1, 2); wr(1'b0, 1);
        run(2);
        chk("R10 period loaded", count, 2);
        chk("R10 toggle bit clear keeps pin", out_pin, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule